// File: doc/BRIEF.md
# Pseudo-Static RAM Access Controller

This block sits on the synchronous side of a chip and runs a 64K x 8 asynchronous pseudo-static memory. A host hands it one access at a time over a valid/ready handshake: a read, a write, or a read-modify-write that returns the old byte and stores a new one. The controller frames every access with a single low pulse on the active-low chip enable. It steers output enable, the read/write strobe and a split data bus (separate out, in and drive-enable) so that the bus is never driven while the memory may be driving it. A mandatory high gap separates consecutive pulses.

All memory timings are given in nanoseconds as parameters. They are turned into whole clock cycles by rounding up against a clock-period parameter. After reset the controller keeps the memory deselected for the power-up pause, then runs a fixed number of dummy read cycles before it opens the handshake. Between host cycles it can hand an idle slot to an outside refresh agent, which keeps the memory deselected for as long as it holds its request.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is high and right after it, `mem_ce1_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, `req_ready` is low, and `mem_ce2` is high at all times.
- R2: `req_ready` stays low until at least INIT_NS has passed since reset release and DUMMY_N chip-enable pulses (dummy reads at address 0) have completed. Dummy reads raise no `rsp_valid`.
- R3: Op code 1 (write) gives one chip-enable pulse with `mem_we_n` low and the bus driving `req_wdata`. The strobe rises no earlier than the chip enable, so the memory keeps that byte at `req_addr`.
- R4: Op code 0 (read), and the unused code 3, assert `mem_oe_n` with the chip enable. The controller samples `mem_dq_in` only once both the chip-enable and output-enable access times have passed. It then gives exactly one one-cycle `rsp_valid` with that byte on `rsp_rdata`. A write gives no `rsp_valid`.
- R5: Op code 2 (read-modify-write) reads and then writes within a single chip-enable pulse. `rsp_rdata` returns the old byte and the memory afterwards holds `req_wdata`.
- R6: `refresh_gnt` is raised only while no chip-enable pulse is active and no host access is in progress. While it is high, `mem_ce1_n` is high and `req_ready` is low. It falls once `refresh_req` is dropped.
- R7: Every chip-enable low pulse lasts at least T_CE_NS, and every high gap lasts at least T_PRE_NS.
- R8: Chip-enable falling edges are at least T_RC_NS apart, or at least T_RMW_NS after a read-modify-write pulse.
- R9: `mem_dq_oe` is high only while `mem_we_n` is low and never while `mem_oe_n` is low. In a read-modify-write, at least one clock lies between the rise of `mem_oe_n` and the start of driving.
- R10: `mem_addr` is set at least one clock before the chip-enable falling edge and stays unchanged while the chip enable is low.
- R11: `req_ready` is low whenever the chip enable is low. One handshake yields exactly one memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Byte to store |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Byte read from memory |
| refresh_req | input | 1 | Outside agent asks for an idle slot |
| refresh_gnt | output | 1 | Slot granted, memory deselected |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable, tied high |
| mem_we_n | output | 1 | Read/write strobe, low for write |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from memory |

## Verification
Writes and reads go to addresses whose high bytes differ, with data 0xA5, 0x5A, 0x00 and 0xFF. All-ones and all-zero bytes show that bits are neither stuck nor dropped. Alternating patterns show that bits are not swapped. The memory model in the bench returns a garbage byte until both access times have elapsed, so a sample taken one cycle too early shows up as a wrong byte. A read-modify-write on a location with a known old value tells apart a controller that returns the old byte from one that returns the new one, and one that loses the write. Refresh requests made both while idle and in the middle of an access tell apart a grant that waits for the access to finish from one that cuts into it.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

    localparam int PS_AW = 16;
    localparam int PS_DW = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2
    } psram_op_e;

    typedef enum logic [2:0] {
        S_INIT,
        S_IDLE,
        S_SETUP,
        S_RD,
        S_TURN,
        S_WR,
        S_PRE,
        S_REFR
    } psram_state_e;

    typedef struct packed {
        logic [1:0]       op;
        logic [PS_AW-1:0] addr;
        logic [PS_DW-1:0] wdata;
    } psram_req_t;

    function automatic int cdiv(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_tick.sv
`timescale 1ns/1ps
module psram_tick #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/psram_rdcap.sv
`timescale 1ns/1ps
module psram_rdcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic          valid,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture;
            if (capture)
                data <= din;
        end
    end
endmodule

// File: rtl/psram_ctrl.sv
`timescale 1ns/1ps
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_NS    = 8,
    parameter int T_CE_NS   = 80,
    parameter int T_CEA_NS  = 80,
    parameter int T_OEA_NS  = 30,
    parameter int T_PRE_NS  = 50,
    parameter int T_RC_NS   = 140,
    parameter int T_RMW_NS  = 205,
    parameter int T_WP_NS   = 30,
    parameter int T_DSW_NS  = 30,
    parameter int INIT_NS   = 100000,
    parameter int DUMMY_N   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [PS_AW-1:0] req_addr,
    input  logic [PS_DW-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [PS_DW-1:0] rsp_rdata,
    input  logic             refresh_req,
    output logic             refresh_gnt,
    output logic             mem_ce1_n,
    output logic             mem_ce2,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic [PS_AW-1:0] mem_addr,
    output logic [PS_DW-1:0] mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [PS_DW-1:0] mem_dq_in
);
    // cycle counts, each rounded up to whole clocks
    localparam int N_ACT    = imax(imax(cdiv(T_CE_NS, CLK_NS), cdiv(T_CEA_NS, CLK_NS)),
                                   cdiv(T_OEA_NS, CLK_NS));
    localparam int N_WP     = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DSW_NS, CLK_NS)), 1);
    localparam int N_M_LOW  = N_ACT + 1 + N_WP;
    localparam int N_PRE_RW = imax(imax(cdiv(T_PRE_NS, CLK_NS),
                                        cdiv(T_RC_NS, CLK_NS) - N_ACT - 1), 1);
    localparam int N_PRE_M  = imax(imax(cdiv(T_PRE_NS, CLK_NS),
                                        cdiv(T_RMW_NS, CLK_NS) - N_M_LOW - 1), 1);
    localparam int N_INIT   = imax(cdiv(INIT_NS, CLK_NS), 1);
    localparam int CNT_W    = $clog2(imax(N_INIT, N_M_LOW + N_PRE_M) + 1);
    localparam int DUM_W    = $clog2(DUMMY_N + 1) + 1;

    psram_state_e     state, state_n;
    psram_req_t       cur;
    logic [DUM_W-1:0] dummy_left;
    logic             tz, ld, take, capture;
    logic [CNT_W-1:0] ld_val;

    psram_tick #(.W(CNT_W), .RST_VAL(N_INIT - 1)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .zero     (tz)
    );

    always_comb begin
        state_n = state;
        ld      = 1'b0;
        ld_val  = '0;
        take    = 1'b0;
        unique case (state)
            S_INIT: if (tz) begin
                state_n = S_SETUP;
                ld      = 1'b1;
            end
            S_IDLE: begin
                if (refresh_req)
                    state_n = S_REFR;
                else if (req_valid) begin
                    take    = 1'b1;
                    state_n = S_SETUP;
                    ld      = 1'b1;
                end
            end
            S_SETUP: if (tz) begin
                ld      = 1'b1;
                ld_val  = CNT_W'(N_ACT - 1);
                state_n = (cur.op == OP_WRITE) ? S_WR : S_RD;
            end
            S_RD: if (tz) begin
                ld = 1'b1;
                if (cur.op == OP_RMW)
                    state_n = S_TURN;
                else begin
                    state_n = S_PRE;
                    ld_val  = CNT_W'(N_PRE_RW - 1);
                end
            end
            S_TURN: if (tz) begin
                state_n = S_WR;
                ld      = 1'b1;
                ld_val  = CNT_W'(N_WP - 1);
            end
            S_WR: if (tz) begin
                state_n = S_PRE;
                ld      = 1'b1;
                ld_val  = (cur.op == OP_RMW) ? CNT_W'(N_PRE_M - 1) : CNT_W'(N_PRE_RW - 1);
            end
            S_PRE: if (tz) begin
                if (dummy_left != '0) begin
                    state_n = S_SETUP;
                    ld      = 1'b1;
                end else
                    state_n = S_IDLE;
            end
            S_REFR: if (!refresh_req) begin
                state_n = S_PRE;
                ld      = 1'b1;
                ld_val  = CNT_W'(N_PRE_RW - 1);
            end
            default: state_n = S_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_INIT;
            cur        <= '{op: OP_READ, addr: '0, wdata: '0};
            dummy_left <= DUM_W'(DUMMY_N);
        end else begin
            state <= state_n;
            if (take)
                cur <= '{op: req_op, addr: req_addr, wdata: req_wdata};
            if (state == S_RD && tz && dummy_left != '0)
                dummy_left <= dummy_left - 1'b1;
        end
    end

    assign capture = (state == S_RD) && tz && (dummy_left == '0);

    psram_rdcap #(.DW(PS_DW)) u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .din     (mem_dq_in),
        .valid   (rsp_valid),
        .data    (rsp_rdata)
    );

    assign req_ready   = (state == S_IDLE) && !refresh_req;
    assign refresh_gnt = (state == S_REFR);
    assign mem_ce1_n   = !(state == S_RD || state == S_TURN || state == S_WR);
    assign mem_ce2     = 1'b1;
    assign mem_oe_n    = (state != S_RD);
    assign mem_we_n    = (state != S_WR);
    assign mem_dq_oe   = (state == S_WR);
    assign mem_addr    = cur.addr;
    assign mem_dq_out  = cur.wdata;
endmodule

// File: rtl/psram_ctrl_chk.sv
`timescale 1ns/1ps
module psram_ctrl_chk
    import psram_pkg::*;
#(
    parameter int CLK_NS  = 8,
    parameter int T_CE_NS = 80
) (
    input logic             clk,
    input logic             rst,
    input logic             ce1_n,
    input logic             oe_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic [PS_AW-1:0] addr,
    input logic             req_ready,
    input logic             refresh_gnt,
    input logic             rsp_valid
);
    localparam int MIN_LOW = cdiv(T_CE_NS, CLK_NS);

    logic [15:0] low_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= '0;
        else if (!ce1_n)
            low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1;
        else
            low_cnt <= '0;
    end

    p_bus_no_oe_r9: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n);
    p_bus_on_write_r9: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !we_n);
    p_turn_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> !dq_oe);
    p_addr_setup_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(ce1_n) |-> $stable(addr));
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!ce1_n && $past(!ce1_n)) |-> $stable(addr));
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ce1_n);
    p_gnt_deselect_r6: assert property (@(posedge clk) disable iff (rst)
        refresh_gnt |-> (ce1_n && !req_ready));
    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    p_ce_width_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ce1_n) |-> (low_cnt >= 16'(MIN_LOW)));
endmodule

bind psram_ctrl psram_ctrl_chk #(.CLK_NS(CLK_NS), .T_CE_NS(T_CE_NS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ce1_n       (mem_ce1_n),
    .oe_n        (mem_oe_n),
    .we_n        (mem_we_n),
    .dq_oe       (mem_dq_oe),
    .addr        (mem_addr),
    .req_ready   (req_ready),
    .refresh_gnt (refresh_gnt),
    .rsp_valid   (rsp_valid)
);

// File: tb/tb_psram_ctrl.sv
`timescale 1ns/1ps
module tb_psram_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        refresh_req = 1'b0;
    logic        refresh_gnt;
    logic        ce1_n, ce2, we_n, oe_n, dq_oe;
    logic [15:0] maddr;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = 8'hEE;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    psram_ctrl dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .refresh_req (refresh_req), .refresh_gnt (refresh_gnt),
        .mem_ce1_n (ce1_n), .mem_ce2 (ce2), .mem_we_n (we_n), .mem_oe_n (oe_n),
        .mem_addr (maddr), .mem_dq_out (dq_out), .mem_dq_oe (dq_oe),
        .mem_dq_in (dq_in)
    );

    // ---------------- memory model ----------------
    logic [7:0] mem [0:255];
    logic [7:0] lat;
    realtime t_ce = 0.0, t_oe = 0.0, t_rise = 0.0, t_last_fall = -1.0;
    bit   pend = 0, saw_rd = 0, saw_wr = 0, last_rmw = 0;
    logic [7:0] pdata, paddr;
    int   ce_falls = 0;
    int   v_width = 0, v_gap = 0, v_cycle = 0, v_bus = 0, v_addr = 0;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;

    always @(negedge ce1_n) begin
        if (!rst) begin
            if (t_last_fall >= 0.0) begin
                if ($realtime - t_last_fall < (last_rmw ? 205.0 : 140.0)) v_cycle++;
                if ($realtime - t_rise < 50.0) v_gap++;
            end
            t_last_fall = $realtime;
            ce_falls++;
        end
        t_ce = $realtime;
        lat  = maddr[7:0];
    end
    always @(negedge oe_n) t_oe = $realtime;
    always @(posedge ce1_n) begin
        if (!rst && t_last_fall >= 0.0 && $realtime - t_ce < 80.0) v_width++;
        t_rise   = $realtime;
        last_rmw = saw_rd && saw_wr;
        saw_rd   = 0;
        saw_wr   = 0;
    end
    always @(negedge clk) begin
        if (!ce1_n && !oe_n) saw_rd = 1;
        if (!ce1_n && !we_n) saw_wr = 1;
        if (!ce1_n && !we_n && dq_oe) begin
            pend = 1; pdata = dq_out; paddr = lat;
        end
        if (dq_oe && (!oe_n || we_n)) v_bus++;
        if (!ce1_n && maddr[7:0] != lat) v_addr++;
    end
    always @(posedge we_n or posedge ce1_n) begin
        if (pend) begin
            mem[paddr] = pdata;
            pend = 0;
        end
    end
    initial forever begin
        #1;
        if (!ce1_n && !oe_n && ($realtime - t_ce >= 79.0) && ($realtime - t_oe >= 29.0))
            dq_in = mem[lat];
        else
            dq_in = 8'hEE;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] op, input logic [15:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output int nrsp);
        rd = 8'h00; nrsp = 0;
        @(negedge clk);
        req_op = op; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (rsp_valid) begin nrsp++; rd = rsp_rdata; end
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(ce1_n && oe_n && we_n, "R1 strobes high in reset", {ce1_n, oe_n, we_n}, 7);
        chk(!dq_oe && !req_ready, "R1 bus and ready low in reset", {dq_oe, req_ready}, 0);
        chk(ce2 == 1'b1, "R1 ce2 high", ce2, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(ce1_n && !req_ready, "R1 after release", {ce1_n, req_ready}, 2);
    endtask

    task automatic t_init();
        realtime t0;
        int seen_rsp = 0;
        t0 = $realtime;
        for (int i = 0; i < 20000; i++) begin
            if (req_ready) break;
            if (rsp_valid) seen_rsp++;
            @(negedge clk);
        end
        chk(($realtime - t0) >= 100000.0, "R2 pause before ready (ns)", int'($realtime - t0), 100000);
        chk(ce_falls == 8, "R2 dummy pulses", ce_falls, 8);
        chk(seen_rsp == 0, "R2 no response from dummies", seen_rsp, 0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] rd; int nr;
        access(2'd1, a, d, rd, nr);
        chk(nr == 0, "R4 write gives no rsp", nr, 0);
        chk(mem[a[7:0]] == d, "R3 memory holds written byte", mem[a[7:0]], d);
    endtask

    task automatic t_read(input logic [1:0] op, input logic [15:0] a, input logic [7:0] exp);
        logic [7:0] rd; int nr;
        access(op, a, 8'h00, rd, nr);
        chk(nr == 1, "R4 one rsp per read", nr, 1);
        chk(rd == exp, "R4 read data", rd, exp);
    endtask

    task automatic t_rmw(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] rd, old; int nr;
        old = mem[a[7:0]];
        access(2'd2, a, d, rd, nr);
        chk(nr == 1 && rd == old, "R5 rmw returns old byte", rd, old);
        chk(mem[a[7:0]] == d, "R5 rmw stores new byte", mem[a[7:0]], d);
    endtask

    task automatic t_refresh_idle();
        @(negedge clk);
        refresh_req = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            chk(refresh_gnt && ce1_n && !req_ready, "R6 idle grant deselects",
                {refresh_gnt, ce1_n, req_ready}, 6);
            @(negedge clk);
        end
        refresh_req = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (req_ready) break;
            @(negedge clk);
        end
        chk(req_ready && !refresh_gnt, "R6 grant released", {req_ready, refresh_gnt}, 2);
    endtask

    task automatic t_refresh_busy();
        int bad = 0, nr = 0;
        logic [7:0] rd = 8'h00;
        @(negedge clk);
        req_op = 2'd0; req_addr = 16'h7712; req_valid = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        refresh_req = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (rsp_valid) begin nr++; rd = rsp_rdata; end
            if (refresh_gnt) break;
            if (req_ready) bad++;
            @(negedge clk);
        end
        chk(nr == 1 && rd == mem[8'h12], "R6 access completes before grant", rd, mem[8'h12]);
        chk(refresh_gnt && bad == 0, "R6 grant after access", {refresh_gnt, 8'(bad)}, 256);
        repeat (3) @(negedge clk);
        chk(ce1_n && !req_ready, "R6 busy grant deselects", {ce1_n, req_ready}, 2);
        refresh_req = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (req_ready) break;
            @(negedge clk);
        end
        chk(req_ready, "R6 ready after busy grant", req_ready, 1);
    endtask

    initial begin
        #1000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_init();
        t_write(16'h0012, 8'hA5);
        t_write(16'hFF34, 8'h5A);
        t_write(16'h8056, 8'h00);
        t_write(16'h1178, 8'hFF);
        t_read(2'd0, 16'h0012, 8'hA5);
        t_read(2'd0, 16'hFF34, 8'h5A);
        t_read(2'd0, 16'h8056, 8'h00);
        t_read(2'd3, 16'h1178, 8'hFF);
        t_read(2'd0, 16'h00C3, 8'hC3 ^ 8'h3C);
        t_rmw(16'h0012, 8'h3D);
        t_read(2'd0, 16'h0012, 8'h3D);
        t_rmw(16'h4499, 8'hC6);
        t_refresh_idle();
        t_refresh_busy();
        t_read(2'd0, 16'h4499, 8'hC6);
        chk(v_width == 0 && v_gap == 0, "R7 pulse width and gap", v_width + v_gap, 0);
        chk(v_cycle == 0, "R8 cycle spacing", v_cycle, 0);
        chk(v_bus == 0, "R9 bus discipline", v_bus, 0);
        chk(v_addr == 0, "R10 address stable", v_addr, 0);
        chk(ce_falls == 8 + 14, "R11 one pulse per handshake", ce_falls, 22);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule